// File: doc/BRIEF.md
# Floating-Point Issue Interlock

This block sits in the decode stage of an in-order pipeline whose execution units finish after different numbers of cycles. There is a one-cycle integer ALU, a pipelined floating-point adder, a pipelined floating-point multiplier and a divider that is not pipelined. For each decoded instruction the block is given the unit it targets, its destination register and up to two source registers. The block then decides in the same cycle whether the instruction may leave decode.

The decision rests on a prediction. Each unit's latency is fixed, so the cycle in which a result reaches the single floating-point register write port is known at issue. The block keeps three pieces of state. The first is a per-register countdown to result availability. The second is a bit-per-future-cycle map of write-port reservations. The third is an occupancy counter for the divider. From these it raises a stall for a read-after-write, write-after-write or structural conflict. A conflict-free instruction is issued and recorded. A stalled instruction is expected to be presented again unchanged in the next cycle.

Top module: `fpiss_top`

## Requirements
- R1: After reset no register is pending, the write port is fully free and the divider is idle, so the first instruction of any unit issues without a stall.
- R2: The predicted result latency is 1 cycle for unit code 0 (integer), 4 for code 1 (FP add), 7 for code 2 (FP multiply) and 24 for code 3 (FP divide). A consumer presented in the cycle after its producer issued stalls for latency minus one cycles.
- R3: A divide presented while the divider is occupied stalls with `stallDiv`. The divider is occupied for the 24 cycles starting at a divide's issue cycle.
- R4: An FP instruction whose predicted write cycle (issue cycle plus latency) is already reserved stalls with `stallPort`.
- R5: An FP instruction stalls with `stallRaw` while an enabled source register is the destination of an issued FP instruction whose result is not yet available.
- R6: An FP instruction stalls with `stallWaw` when its destination is pending with a write cycle later than its own predicted write cycle. An earlier pending write to the same register causes no stall.
- R7: A destination that matches a source of an earlier, still-running instruction causes no stall.
- R8: Integer instructions (unit code 0) never stall and leave all FP tracking state unchanged.
- R9: `stall` is the OR of the four causes, and `issue` is `decValid` without `stall`. A stalled instruction changes no tracking state.
- R10: With `decValid` low, `stall`, `issue` and all four causes are low whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | An instruction is present in decode |
| decUnit | input | 2 | Target unit: 0 integer, 1 FP add, 2 FP multiply, 3 FP divide |
| decDst | input | 5 | Destination register |
| decSrcA | input | 5 | First source register |
| decSrcAEn | input | 1 | First source is read |
| decSrcB | input | 5 | Second source register |
| decSrcBEn | input | 1 | Second source is read |
| stall | output | 1 | Hold the instruction in decode |
| issue | output | 1 | Instruction leaves decode this cycle |
| stallDiv | output | 1 | Divider occupied |
| stallPort | output | 1 | Write-port cycle already reserved |
| stallRaw | output | 1 | Source result not yet available |
| stallWaw | output | 1 | Older write to the destination lands later |

## Verification
The hardest situation to reach is the one where the WAW and write-port causes meet on one instruction. A long multiply is followed by a short add to the same register. The add sees WAW stalls first. Then, in the one cycle where both writes would land together, it sees a port stall. Only after that does it issue. The bench arranges this directly with back-to-back multiply and add to one register. It also arranges a port-only collision by placing an add exactly three cycles behind a multiply. A random phase then drives a pool of eight registers and all units every cycle against a behavioural model that holds absolute ready cycles and a queue of reserved write cycles.

// File: rtl/fpiss_pkg.sv
package fpiss_pkg;
  localparam int REGW = 5;
  localparam int CNTW = 6;

  typedef enum logic [1:0] {
    UNIT_INT = 2'd0,
    UNIT_ADD = 2'd1,
    UNIT_MUL = 2'd2,
    UNIT_DIV = 2'd3
  } unit_e;

  // strobes from the decision logic to the tracking state
  typedef struct packed {
    logic            issue;
    logic            track;
    logic            isDiv;
    logic [REGW-1:0] dst;
    logic [CNTW-1:0] lat;
  } strobe_t;
endpackage

// File: rtl/fpiss_track.sv
module fpiss_track
  import fpiss_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int LAT_DIV = 24,
  localparam int PORTW  = LAT_DIV + 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        strb,
  output logic [NREG-1:0][CNTW-1:0]      pendCnt,
  output logic [PORTW-1:0]               portRes,
  output logic                           divBusy
);

  logic [CNTW-1:0]  divCnt;
  logic [PORTW-1:0] portSet;
  logic             record;

  assign record  = strb.issue && strb.track;
  assign divBusy = (divCnt != '0);

  // per-register countdown until the result can be read
  for (genvar r = 0; r < NREG; r++) begin : gPend
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendCnt[r] <= '0;
      end else if (record && (strb.dst == REGW'(r))) begin
        pendCnt[r] <= strb.lat - CNTW'(1);
      end else if (pendCnt[r] != '0) begin
        pendCnt[r] <= pendCnt[r] - CNTW'(1);
      end
    end
  end

  always_comb begin
    portSet = '0;
    if (record) portSet[strb.lat - CNTW'(1)] = 1'b1;
  end

  // bit k set: the write port is taken k cycles from now
  always_ff @(posedge clk) begin
    if (!rstN) portRes <= '0;
    else       portRes <= (portRes >> 1) | portSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (strb.issue && strb.isDiv) begin
      divCnt <= CNTW'(LAT_DIV - 1);
    end else if (divCnt != '0) begin
      divCnt <= divCnt - CNTW'(1);
    end
  end

  AST_PORT_FREE_AT_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    record |-> !portRes[strb.lat]);  // R4
  AST_DIV_IDLE_AT_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && strb.isDiv) |-> !divBusy);  // R3
  AST_DIV_OCCUPIED_AFTER: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && strb.isDiv) |=> divBusy);  // R3
  AST_PEND_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    record |=> (pendCnt[$past(strb.dst)] == $past(strb.lat) - CNTW'(1)));  // R2
  AST_PORT_MARKED: assert property (@(posedge clk) disable iff (!rstN)
    record |=> portRes[$past(strb.lat) - CNTW'(1)]);  // R4
  AST_IDLE_HOLDS_DIV: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.issue && !divBusy) |=> !divBusy);  // R9

endmodule

// File: rtl/fpiss_ctrl.sv
module fpiss_ctrl
  import fpiss_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 4,
  parameter int LAT_MUL = 7,
  parameter int LAT_DIV = 24,
  localparam int PORTW  = LAT_DIV + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      decValid,
  input  logic [1:0]                decUnit,
  input  logic [REGW-1:0]           decDst,
  input  logic [REGW-1:0]           decSrcA,
  input  logic                      decSrcAEn,
  input  logic [REGW-1:0]           decSrcB,
  input  logic                      decSrcBEn,
  input  logic [NREG-1:0][CNTW-1:0] pendCnt,
  input  logic [PORTW-1:0]          portRes,
  input  logic                      divBusy,
  output logic                      stall,
  output logic                      issue,
  output logic                      stallDiv,
  output logic                      stallPort,
  output logic                      stallRaw,
  output logic                      stallWaw,
  output strobe_t                   strb
);

  unit_e           unit;
  logic            isFp;
  logic [CNTW-1:0] lat;
  logic            rawA, rawB;

  always_comb begin
    unit = unit_e'(decUnit);
    isFp = (unit != UNIT_INT);
    unique case (unit)
      UNIT_ADD: lat = CNTW'(LAT_ADD);
      UNIT_MUL: lat = CNTW'(LAT_MUL);
      UNIT_DIV: lat = CNTW'(LAT_DIV);
      default:  lat = CNTW'(LAT_INT);
    endcase

    rawA      = decSrcAEn && (pendCnt[decSrcA] != '0);
    rawB      = decSrcBEn && (pendCnt[decSrcB] != '0);
    stallRaw  = decValid && isFp && (rawA || rawB);
    stallWaw  = decValid && isFp && (pendCnt[decDst] > lat);
    stallPort = decValid && isFp && portRes[lat];
    stallDiv  = decValid && (unit == UNIT_DIV) && divBusy;
    stall     = stallRaw || stallWaw || stallPort || stallDiv;
    issue     = decValid && !stall;

    strb.issue = issue;
    strb.track = isFp;
    strb.isDiv = (unit == UNIT_DIV);
    strb.dst   = decDst;
    strb.lat   = lat;
  end

  AST_ISSUE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    issue |-> decValid);  // R10
  AST_ISSUE_SRC_A_READY: assert property (@(posedge clk) disable iff (!rstN)
    (issue && isFp && decSrcAEn) |-> (pendCnt[decSrcA] == '0));  // R5
  AST_ISSUE_SRC_B_READY: assert property (@(posedge clk) disable iff (!rstN)
    (issue && isFp && decSrcBEn) |-> (pendCnt[decSrcB] == '0));  // R5
  AST_ISSUE_NO_LATE_WRITER: assert property (@(posedge clk) disable iff (!rstN)
    (issue && isFp) |-> (pendCnt[decDst] <= lat));  // R6
  AST_INT_NEVER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !isFp) |-> issue);  // R8

endmodule

// File: rtl/fpiss_top.sv
module fpiss_top
  import fpiss_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 4,
  parameter int LAT_MUL = 7,
  parameter int LAT_DIV = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       decValid,
  input  logic [1:0] decUnit,
  input  logic [4:0] decDst,
  input  logic [4:0] decSrcA,
  input  logic       decSrcAEn,
  input  logic [4:0] decSrcB,
  input  logic       decSrcBEn,
  output logic       stall,
  output logic       issue,
  output logic       stallDiv,
  output logic       stallPort,
  output logic       stallRaw,
  output logic       stallWaw
);

  localparam int PORTW = LAT_DIV + 1;

  strobe_t                   strb;
  logic [NREG-1:0][CNTW-1:0] pendCnt;
  logic [PORTW-1:0]          portRes;
  logic                      divBusy;

  fpiss_ctrl #(
    .NREG(NREG), .LAT_INT(LAT_INT), .LAT_ADD(LAT_ADD),
    .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .decValid(decValid), .decUnit(decUnit), .decDst(decDst),
    .decSrcA(decSrcA), .decSrcAEn(decSrcAEn),
    .decSrcB(decSrcB), .decSrcBEn(decSrcBEn),
    .pendCnt(pendCnt), .portRes(portRes), .divBusy(divBusy),
    .stall(stall), .issue(issue),
    .stallDiv(stallDiv), .stallPort(stallPort),
    .stallRaw(stallRaw), .stallWaw(stallWaw),
    .strb(strb)
  );

  fpiss_track #(
    .NREG(NREG), .LAT_DIV(LAT_DIV)
  ) uTrack (
    .clk(clk), .rstN(rstN), .strb(strb),
    .pendCnt(pendCnt), .portRes(portRes), .divBusy(divBusy)
  );

endmodule

// File: tb/fpiss_top_test.sv
`timescale 1ns/1ps
module fpiss_top_test;
  localparam int LDIV = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic decValid = 1'b0;
  logic [1:0] decUnit = '0;
  logic [4:0] decDst = '0, decSrcA = '0, decSrcB = '0;
  logic decSrcAEn = 1'b0, decSrcBEn = 1'b0;
  logic stall, issue, stallDiv, stallPort, stallRaw, stallWaw;

  int checks = 0;
  int errors = 0;

  // behavioural model: absolute cycle numbers
  int readyAt [32];
  int portQ [$];
  int divFreeAt;
  int cyc;

  always #2.5 clk = ~clk;

  fpiss_top uut (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decUnit(decUnit),
    .decDst(decDst), .decSrcA(decSrcA), .decSrcAEn(decSrcAEn),
    .decSrcB(decSrcB), .decSrcBEn(decSrcBEn),
    .stall(stall), .issue(issue), .stallDiv(stallDiv),
    .stallPort(stallPort), .stallRaw(stallRaw), .stallWaw(stallWaw)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int latOf(int u);
    case (u)
      1: return 4;
      2: return 7;
      3: return LDIV;
      default: return 1;
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rstN) begin
      foreach (readyAt[i]) readyAt[i] = 0;
      portQ.delete();
      divFreeAt = 0;
      cyc = 0;
    end else begin
      int u, l;
      bit fp, eRaw, eWaw, ePort, eDiv, eStall, eIssue;
      u = decUnit;
      l = latOf(u);
      fp = (u != 0);
      for (int k = portQ.size() - 1; k >= 0; k--)
        if (portQ[k] < cyc) portQ.delete(k);
      eRaw = decValid && fp &&
             ((decSrcAEn && cyc < readyAt[decSrcA]) || (decSrcBEn && cyc < readyAt[decSrcB]));
      eWaw = decValid && fp && (readyAt[decDst] > cyc + l);
      ePort = 1'b0;
      foreach (portQ[k]) if (portQ[k] == cyc + l) ePort = 1'b1;
      ePort = ePort && decValid && fp;
      eDiv = decValid && (u == 3) && (cyc < divFreeAt);
      eStall = eRaw || eWaw || ePort || eDiv;
      eIssue = decValid && !eStall;
      check("R5 stallRaw", stallRaw, eRaw);
      check("R6 stallWaw", stallWaw, eWaw);
      check("R4 stallPort", stallPort, ePort);
      check("R3 stallDiv", stallDiv, eDiv);
      check("R9 stall", stall, eStall);
      check("R9 issue", issue, eIssue);
      if (!decValid) check("R10 idle stall", stall, 0);
      if (decValid && !fp) check("R8 integer issue", issue, 1);
      if (eIssue && fp) begin
        readyAt[decDst] = cyc + l;
        portQ.push_back(cyc + l);
        if (u == 3) divFreeAt = cyc + LDIV;
      end
      cyc++;
    end
  end

  task automatic idle(int n);
    decValid = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  // hold one instruction in decode until it issues; returns stalled cycles
  task automatic present(int u, int d, int a, bit ae, int b, bit be, output int stalls);
    decValid = 1'b1; decUnit = 2'(u); decDst = 5'(d);
    decSrcA = 5'(a); decSrcAEn = ae; decSrcB = 5'(b); decSrcBEn = be;
    stalls = 0;
    forever begin
      @(negedge clk); #1;
      if (issue) break;
      stalls++;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    decValid = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog R9 actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1;
    check("R1 reset stall", stall, 0);
    check("R1 reset issue", issue, 0);
    @(posedge clk); #1;

    present(3, 1, 0, 0, 0, 0, s); check("R1 first divide no stall", s, 0);
    idle(30);

    // R2 latencies seen through a dependent consumer
    present(1, 2, 0, 0, 0, 0, s); present(1, 3, 2, 1, 0, 0, s);
    check("R2 add consumer stalls", s, 3);
    idle(10);
    present(2, 4, 0, 0, 0, 0, s); present(1, 5, 0, 0, 4, 1, s);
    check("R2 multiply consumer stalls", s, 6);
    idle(10);
    present(3, 6, 0, 0, 0, 0, s); present(1, 7, 6, 1, 6, 1, s);
    check("R2 divide consumer stalls", s, 23);
    idle(30);

    // R3 back-to-back divides
    present(3, 8, 0, 0, 0, 0, s); present(3, 9, 0, 0, 0, 0, s);
    check("R3 second divide stalls", s, 23);
    idle(30);

    // R4 add lands on the multiply's write cycle
    present(2, 10, 0, 0, 0, 0, s); idle(2);
    present(1, 11, 0, 0, 0, 0, s);
    check("R4 port collision stalls", s, 1);
    idle(10);

    // R6 later writer pending, then earlier writer pending
    present(2, 12, 0, 0, 0, 0, s); present(1, 12, 0, 0, 0, 0, s);
    check("R6 WAW then port stalls", s, 3);
    idle(10);
    present(1, 13, 0, 0, 0, 0, s); present(2, 13, 0, 0, 0, 0, s);
    check("R6 earlier writer no stall", s, 0);
    idle(10);

    // R7 destination overlaps an earlier source
    present(2, 14, 15, 1, 15, 1, s); present(1, 15, 0, 0, 0, 0, s);
    check("R7 WAR no stall", s, 0);
    idle(10);

    // R8 integer op touching a pending FP number leaves state alone
    present(2, 16, 0, 0, 0, 0, s);
    present(0, 16, 16, 1, 16, 1, s); check("R8 integer no stall", s, 0);
    present(1, 17, 16, 1, 0, 0, s); check("R8 state untouched", s, 5);
    idle(10);

    // R10 invalid slot carrying a pending source
    present(2, 18, 0, 0, 0, 0, s);
    decSrcA = 5'd18; decSrcAEn = 1'b1; decUnit = 2'd1; decDst = 5'd18;
    @(negedge clk); #1;
    check("R10 invalid not stalled", stall, 0);
    check("R10 invalid not issued", issue, 0);
    idle(12);

    // random traffic, every cycle compared by the model
    for (int i = 0; i < 3000; i++) begin
      decValid = ($urandom_range(0, 3) != 0);
      decUnit = 2'($urandom_range(0, 3));
      decDst = 5'($urandom_range(0, 7));
      decSrcA = 5'($urandom_range(0, 7));
      decSrcB = 5'($urandom_range(0, 7));
      decSrcAEn = 1'($urandom_range(0, 1));
      decSrcBEn = 1'($urandom_range(0, 1));
      @(posedge clk); #1;
    end
    idle(30);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule